// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Incrementer Groups

This block adds two unsigned N-bit operands and a carry-in. It returns an N-bit sum and a carry-out, and the result equals ordinary binary addition. The block has no clock and no state, so it can be placed anywhere in a datapath cone as a direct replacement for a `+` operator. The operand width is a parameter and may be set to 16, 32, 64 or 128 bits.

The bits are split into groups whose widths grow toward the most significant end. The bottom group is a plain ripple adder that is fed the external carry-in. Each higher group computes only one candidate result, using a ripple adder with its carry-in tied low. The second candidate, which would apply if the incoming carry were high, is formed by a compact incrementer that adds one to that result. The incrementer is one bit wider than the group, so the candidate's carry-out is included. The carry-out of each group steers a 2:1 selector in the group above it. The carry-out of the top group becomes the block's carry-out.

For N = 16 the group widths, from the least significant end, are 2, 2, 3, 4 and 5. For larger N the sequence continues as 6, 7, 8 and so on. A group is added only while the next group in the sequence still fits. Otherwise the current group absorbs all remaining bits, so the widths never decrease.

Top module: `sqrt_csel_add`

## Requirements
- R1: For every operand pair and carry-in, the value {cout_o, sum_o} equals a_i + b_i + cin_i, computed at N+1 bits.
- R2: sum_o[1:0] always equals the low two bits of a_i[1:0] + b_i[1:0] + cin_i. This is the bottom ripple group, the only group fed directly by the external carry-in.
- R3: A carry produced at any bit position reaches the next bit, including across every group boundary. For any k in 1..N-1, the operands a_i = 2^k - 1, b_i = 1 and cin_i = 0 give sum_o = 2^k and cout_o = 0.
- R4: When both operands are all ones and cin_i = 1, sum_o is all ones and cout_o = 1.
- R5: When a_i is all ones, b_i = 0 and cin_i = 1, sum_o = 0 and cout_o = 1. The carry passes through the selector of every group.
- R6: cout_o reflects an overflow out of the top group. For a_i = b_i = 2^(N-1) and cin_i = 0, sum_o = 0 and cout_o = 1.
- R7: With both operands zero, sum_o equals cin_i and cout_o = 0.
- R8: The same RTL elaborates and satisfies R1 at N = 16, 32, 64 and 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand, unsigned |
| b_i | input | N | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Low N bits of the sum |
| cout_o | output | 1 | Carry out of bit N-1 |

## Verification
The bench builds four copies of the adder at N = 16, 32, 64 and 128. All four copies are driven from one 128-bit stimulus, and each copy sees the low bits that fit its width. With every width present, each group-split rule is exercised. This includes the 32-bit split, whose top group absorbs a three-bit remainder, and the wide top groups at 64 and 128 bits. A sweep of carry chains of every length from 1 to 127 bits crosses every group boundary of every configuration. Random operands and the all-ones and overflow corners complete the coverage.

// File: rtl/csa_pkg.sv
package csa_pkg;

  localparam int MAX_GROUPS = 32;

  // Nominal width of group g before the final group absorbs the remainder.
  function automatic int seq_width(input int g);
    return (g < 2) ? 2 : g + 1;
  endfunction

  // Actual width of group g for an n-bit adder (0 when group g is absent).
  function automatic int grp_width(input int n, input int g);
    int pos;
    int w;
    pos = 0;
    for (int k = 0; k < MAX_GROUPS; k++) begin
      if (pos >= n) return 0;
      w = seq_width(k);
      if (pos + w + seq_width(k + 1) > n) w = n - pos;
      if (k == g) return w;
      pos = pos + w;
    end
    return 0;
  endfunction

  // Bit index of the least significant bit of group g.
  function automatic int grp_lsb(input int n, input int g);
    int pos;
    pos = 0;
    for (int k = 0; k < g; k++) pos = pos + grp_width(n, k);
    return pos;
  endfunction

  // Number of groups that an n-bit adder is split into.
  function automatic int grp_count(input int n);
    for (int k = 0; k < MAX_GROUPS; k++)
      if (grp_width(n, k) == 0) return k;
    return MAX_GROUPS;
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W:0] chain;

  assign chain[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic hp;
    assign hp          = x_i[i] ^ y_i[i];
    assign s_o[i]      = hp ^ chain[i];
    assign chain[i+1]  = (x_i[i] & y_i[i]) | (hp & chain[i]);
  end

  assign c_o = chain[W];

endmodule

// File: rtl/csa_xs1.sv
module csa_xs1 #(
  parameter int W = 5
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] v_o
);

  // Running AND of the lower bits: a bit toggles when all bits below it are 1.
  logic [W-1:0] all_low;

  assign all_low[0] = v_i[0];
  assign v_o[0]     = ~v_i[0];

  for (genvar i = 1; i < W; i++) begin : g_inc
    assign all_low[i] = all_low[i-1] & v_i[i];
    assign v_o[i]     = v_i[i] ^ all_low[i-1];
  end

endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int W    = 2,
  parameter bit BASE = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  if (BASE) begin : g_base
    // Bottom group: single ripple adder fed by the true carry-in.
    csa_ripple #(.W(W)) u_rca (
      .x_i(a_i), .y_i(b_i), .c_i(sel_i), .s_o(s_o), .c_o(c_o)
    );
  end else begin : g_sel
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W:0]   cand_one;

    csa_ripple #(.W(W)) u_rca (
      .x_i(a_i), .y_i(b_i), .c_i(1'b0), .s_o(s_zero), .c_o(c_zero)
    );

    // The carry-in-of-one candidate is the carry-in-of-zero result plus one.
    csa_xs1 #(.W(W + 1)) u_inc (
      .v_i({c_zero, s_zero}), .v_o(cand_one)
    );

    assign {c_o, s_o} = sel_i ? cand_one : {c_zero, s_zero};
  end

endmodule

// File: rtl/sqrt_csel_add.sv
module sqrt_csel_add #(
  parameter int N = 16
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  import csa_pkg::*;

  localparam int NG = grp_count(N);

  logic [NG:0] gcar;

  assign gcar[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LSB = grp_lsb(N, g);
    localparam int GW  = grp_width(N, g);

    csa_group #(.W(GW), .BASE(g == 0)) u_grp (
      .a_i  (a_i[LSB +: GW]),
      .b_i  (b_i[LSB +: GW]),
      .sel_i(gcar[g]),
      .s_o  (sum_o[LSB +: GW]),
      .c_o  (gcar[g+1])
    );
  end

  assign cout_o = gcar[NG];

endmodule

// File: rtl/sqrt_csel_add_chk.sv
module sqrt_csel_add_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [N-1:0] sum_o,
  input logic         cout_o
);

  logic [N:0] full_ref;
  logic [2:0] low_ref;

  assign full_ref = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
  assign low_ref  = {1'b0, a_i[1:0]} + {1'b0, b_i[1:0]} + {2'b00, cin_i};

  always_comb begin
    AST_SUM_EXACT: assert ({cout_o, sum_o} == full_ref); // R1
    AST_LOW_GROUP: assert (sum_o[1:0] == low_ref[1:0]); // R2
    if (&a_i && &b_i && cin_i)
      AST_ALL_ONES: assert (&sum_o && cout_o); // R4
    if (&a_i && b_i == '0 && cin_i)
      AST_FULL_WRAP: assert (sum_o == '0 && cout_o); // R5
    if (a_i == '0 && b_i == '0)
      AST_ZERO_OPS: assert (sum_o == {{(N-1){1'b0}}, cin_i} && !cout_o); // R7
  end

endmodule

bind sqrt_csel_add sqrt_csel_add_chk #(.N(N)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o)
);

// File: tb/tb_sqrt_csel_add.sv
`timescale 1ns/1ps
module tb_sqrt_csel_add;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [127:0] a = '0;
  logic [127:0] b = '0;
  logic         cin = 1'b0;

  logic [15:0]  s16;  logic c16;
  logic [31:0]  s32;  logic c32;
  logic [63:0]  s64;  logic c64;
  logic [127:0] s128; logic c128;

  sqrt_csel_add #(.N(16)) dut (
    .a_i(a[15:0]), .b_i(b[15:0]), .cin_i(cin), .sum_o(s16), .cout_o(c16));
  sqrt_csel_add #(.N(32)) dut_w32 (
    .a_i(a[31:0]), .b_i(b[31:0]), .cin_i(cin), .sum_o(s32), .cout_o(c32));
  sqrt_csel_add #(.N(64)) dut_w64 (
    .a_i(a[63:0]), .b_i(b[63:0]), .cin_i(cin), .sum_o(s64), .cout_o(c64));
  sqrt_csel_add #(.N(128)) dut_w128 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s128), .cout_o(c128));

  typedef struct {
    logic [128:0] e16;
    logic [128:0] e32;
    logic [128:0] e64;
    logic [128:0] e128;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [128:0] ref_sum(input int w, input logic [127:0] x,
                                           input logic [127:0] y, input logic c);
    logic [128:0] mask;
    mask = (129'd1 << w) - 129'd1;
    return ({1'b0, x} & mask) + ({1'b0, y} & mask) + {128'd0, c};
  endfunction

  task automatic drive(input logic [127:0] x, input logic [127:0] y,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    a   <= x;
    b   <= y;
    cin <= c;
    it.e16  = ref_sum(16, x, y, c);
    it.e32  = ref_sum(32, x, y, c);
    it.e64  = ref_sum(64, x, y, c);
    it.e128 = ref_sum(128, x, y, c);
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string tag, input int w,
                     input logic [128:0] got, input logic [128:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s N=%0d got=%h exp=%h", tag, w, got, exp);
    end
  endtask

  // Monitor: compares outputs half a period after the driver changed inputs.
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.tag, 16,  {112'd0, c16, s16},   it.e16);
      cmp(it.tag, 32,  {96'd0, c32, s32},    it.e32);
      cmp(it.tag, 64,  {64'd0, c64, s64},    it.e64);
      cmp(it.tag, 128, {c128, s128},         it.e128);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired with %0d items pending", q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // R7: zero operands, both carry-in values (also the idle state)
    drive('0, '0, 1'b0, "R7");
    drive('0, '0, 1'b1, "R7");
    // R4: all ones plus all ones plus carry-in
    drive({128{1'b1}}, {128{1'b1}}, 1'b1, "R4");
    // R5: all ones plus carry-in only
    drive({128{1'b1}}, '0, 1'b1, "R5");
    // R6: top-bit overflow at each width
    drive(128'h8000, 128'h8000, 1'b0, "R6");
    drive(128'h8000_0000, 128'h8000_0000, 1'b0, "R6");
    drive(128'h8000_0000_0000_0000, 128'h8000_0000_0000_0000, 1'b0, "R6");
    drive({1'b1, 127'd0}, {1'b1, 127'd0}, 1'b0, "R6");
    // R2: every low-pair combination with carry-in
    for (int v = 0; v < 32; v++)
      drive(128'(v[1:0]), 128'(v[3:2]), v[4], "R2");
    // R3: carry chains of every length cross every group boundary
    for (int k = 1; k < 128; k++)
      drive((128'd1 << k) - 128'd1, 128'd1, 1'b0, "R3");
    // R1 / R8: random operands at every width
    for (int n = 0; n < 200; n++)
      drive({$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, 1'($urandom), "R1_R8");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule